// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a burst starts, it takes the full external address. The upper bits are held for the whole burst. The two low bits become the start offset. Each cycle in which the active-low advance strobe is asserted moves the low bits to the next beat.

A mode input selects the beat order. When the mode input is low, the low bits count upward by one, modulo four. When it is high, the low bits are the start offset XORed with a running beat count, so the order depends on where the burst began. After four advances the low bits are back at the start offset.

A load may arrive on any cycle. It restarts the sequence and wins over an advance in the same cycle. The output is registered, and a cycle with neither load nor advance leaves it unchanged. Command decode and memory access are outside the block, which only receives the load and advance strobes.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `burst_addr` becomes all zeros.
- R2: When `load` is high at a clock edge, `burst_addr` equals `ext_addr` after that edge. The upper bits `ext_addr[ADDR_W-1:2]` are captured, and `ext_addr[1:0]` becomes the start offset with the beat count cleared.
- R3: With `ilv_mode` low (linear order), each advance sets `burst_addr[1:0]` to the start offset plus the beat count, modulo 4. From a start of 01 this gives 10, 11, 00.
- R4: With `ilv_mode` high (interleaved order), each advance sets `burst_addr[1:0]` to the start offset XOR the beat count. From a start of 10 this gives 11, 00, 01.
- R5: An advance is an edge with `adv_n` low and `load` low, and each advance adds one to the 2-bit beat count. The fourth advance after a load returns `burst_addr[1:0]` to the start offset, in either order.
- R6: At an edge with `adv_n` high and `load` low, `burst_addr` keeps its value.
- R7: When `load` is high and `adv_n` is low at the same edge, the load takes effect and no advance happens.
- R8: `burst_addr[ADDR_W-1:2]` changes only on a load. A wrap of the low bits from 11 to 00 does not carry into the upper bits.
- R9: A load in the middle of a burst restarts the sequence from the new start offset, with the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a burst from `ext_addr` |
| adv_n | input | 1 | Advance to the next beat, active low |
| ilv_mode | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Current beat address, registered |

## Verification
The hardest case to reach is a complete wrap in which the low bits roll from 11 to 00 while the upper field is all ones. This is the only case where a carry into the upper bits would show. The stimulus loads an all-ones address in linear order and advances four times.

Interleaved bursts from each non-zero offset are also driven through a full wrap. Hold cycles are placed between advances to show that the beat count stays put while the output holds.

The priority of load over advance is exercised by asserting both strobes together, once at the start of a burst and once mid-burst. In each case the expected address is the new start address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [BEAT_W-1:0] start_off,
  output logic [BEAT_W-1:0] offset_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  assign beat_nxt = beat_q + BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      beat_q   <= '0;
    end else if (load) begin
      offset_q <= start_off;
      beat_q   <= '0;
    end else if (step) begin
      beat_q   <= beat_nxt;
    end
  end

  // R9
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0) && (offset_q == $past(start_off)));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> beat_q == BEAT_W'($past(beat_q) + 1));

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(beat_q) && $stable(offset_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] offset,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_addr
);
  logic [BEAT_W-1:0] lin_addr;
  logic [BEAT_W-1:0] ilv_addr;

  assign lin_addr = offset + beat;
  assign ilv_addr = offset ^ beat;

  always_comb begin
    case (order)
      ORD_INTERLEAVE: low_addr = ilv_addr;
      default:        low_addr = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              advance;
  logic [BEAT_W-1:0] offset_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [BEAT_W-1:0] low_q;
  logic [UP_W-1:0]   upper_q;
  burst_order_e      order;

  assign advance = !adv_n && !load;
  assign order   = burst_order_e'(ilv_mode);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (advance),
    .start_off (ext_addr[BEAT_W-1:0]),
    .offset_q  (offset_q),
    .beat_q    (beat_q),
    .beat_nxt  (beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order    (order),
    .offset   (offset_q),
    .beat     (beat_nxt),
    .low_addr (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      low_q   <= '0;
    end else if (load) begin
      upper_q <= ext_addr[ADDR_W-1:BEAT_W];
      low_q   <= ext_addr[BEAT_W-1:0];
    end else if (advance) begin
      low_q   <= low_nxt;
    end
  end

  assign burst_addr = {upper_q, low_q};

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> burst_addr == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> burst_addr == $past(ext_addr));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_n && !load) |=> $stable(burst_addr));

  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(upper_q));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !ilv_mode) |=> low_q == BEAT_W'(offset_q + beat_q));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && ilv_mode) |=> low_q == (offset_q ^ beat_q));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          load;
  logic          adv_n;
  logic          ilv_mode;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] burst_addr;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  logic [AW-3:0] m_up;
  logic [1:0]    m_off;
  logic [1:0]    m_beat;
  logic [AW-1:0] m_out;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk(clk), .rst(rst), .load(load), .adv_n(adv_n),
    .ilv_mode(ilv_mode), .ext_addr(ext_addr), .burst_addr(burst_addr)
  );

  task automatic step(input bit ld, input bit an, input bit md,
                      input logic [AW-1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    load = ld; adv_n = an; ilv_mode = md; ext_addr = a;
    if (ld) begin
      m_up = a[AW-1:2]; m_off = a[1:0]; m_beat = 2'd0; m_out = a;
    end else if (!an) begin
      m_beat = m_beat + 2'd1;
      m_out  = {m_up, (md ? (m_off ^ m_beat) : 2'(m_off + m_beat))};
    end
    it.exp = m_out; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (burst_addr !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, burst_addr, it.exp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load = 1'b0; adv_n = 1'b1; ilv_mode = 1'b1; ext_addr = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (burst_addr !== '0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=%h", burst_addr, {AW{1'b0}});
    end
    rst = 1'b0;
    m_up = '0; m_off = '0; m_beat = '0; m_out = '0;

    // R2 + R3 + R5: linear from offset 01, four advances wrap to start
    step(1, 1, 0, 20'h12345, "R2 load");
    step(0, 0, 0, '0, "R3 linear beat1");
    step(0, 0, 0, '0, "R3 linear beat2");
    step(0, 1, 0, '0, "R6 hold mid-burst");
    step(0, 1, 0, '0, "R6 hold again");
    step(0, 0, 0, '0, "R3 linear beat3");
    step(0, 0, 0, '0, "R5 linear wrap");

    // R4 + R5: interleaved from every offset
    for (int s = 0; s < 4; s++) begin
      step(1, 1, 1, {18'h2A5C3, 2'(s)}, "R2 load ilv");
      for (int b = 0; b < 4; b++)
        step(0, 0, 1, '0, (b == 3) ? "R5 interleave wrap" : "R4 interleave beat");
    end

    // R8: all-ones address, linear wrap 11 -> 00 must not carry
    step(1, 1, 0, 20'hFFFFF, "R2 load ones");
    for (int b = 0; b < 4; b++)
      step(0, 0, 0, '0, "R8 no carry into upper");

    // R7: load and advance together
    step(1, 0, 0, 20'h0ABC6, "R7 load beats advance");
    step(0, 0, 0, '0, "R3 after priority load");

    // R9: restart mid-burst, with load+advance
    step(1, 0, 1, 20'h55551, "R9 restart load");
    step(0, 0, 1, '0, "R9 first beat after restart");
    step(0, 0, 1, '0, "R4 beat2 after restart");
    step(0, 1, 1, '0, "R6 hold ilv");

    step(0, 1, 1, '0, "R6 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule